// File: doc/BRIEF.md
# Dual-Channel Serial DAC Front End

This block is the digital front end of a two-channel, 16-bit serial-input converter. A three-wire serial port carries words into an 18-bit shift register. The three wires are an active-low select, a serial clock and a data line. When the select line returns high, the word that was shifted in is written to the input register of each channel its address bits name. A separate active-low load line moves the input registers into the converter registers. The parallel codes of those converter registers are the block's outputs and drive the analog stage.

The interface is sampled by a fast system clock. Every pin passes through a synchroniser of two flip-flops. Edges are found by comparing each synchronised value with its value one cycle earlier. An active-low clear pin forces both register stages of both channels to a preset code. A second pin chooses that preset: zero or midscale. The system reset puts every register at zero, which is the power-on state.

Top module: `sdac_front`

## Requirements
- R1: After the system reset `rst`, both output codes and both input registers are 0x0000.
- R2: The shift register takes one bit, with the data line entering at the LSB, on each synchronised rising edge of `sclk` while `cs_n` is low. Edges of `sclk` while `cs_n` is high leave the shift register unchanged.
- R3: On a rising edge of `cs_n`, the 18-bit word is split as follows. Bits [15:0] are the data. Bit 16 enables a write to channel A and bit 17 enables a write to channel B. Sent MSB first, the address pair 01 selects A, 10 selects B, 11 selects both and 00 selects neither.
- R4: A rising edge of `cs_n` while `load_n` is high leaves both output codes unchanged.
- R5: While `load_n` is low and `clr_n` is high, each output code follows its input register, including a write made in the same cycle.
- R6: Once `load_n` is high again, the output codes hold their values while later words are written to the input registers.
- R7: While `clr_n` is low and `mid_sel` is low, both input registers and both output codes are 0x0000.
- R8: While `clr_n` is low and `mid_sel` is high, both input registers and both output codes are 0x8000.
- R9: While `clr_n` is low, a rising edge of `cs_n` and a low `load_n` have no effect. The clear value is kept in both register stages.
- R10: A rising edge of `cs_n` after fewer than 18 serial clocks transfers the shift register exactly as it stands. That is the previous contents shifted left by the number of new bits, with the new bits at the bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the interface pins |
| rst | input | 1 | Synchronous active-high reset (power-on state) |
| cs_n | input | 1 | Serial frame select, active low; a rising edge transfers the word |
| sclk | input | 1 | Serial clock; a rising edge shifts one bit |
| sdi | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Load line for the converter registers; low = transparent |
| clr_n | input | 1 | Clear, active low, level sensitive |
| mid_sel | input | 1 | Clear target: 0 = zero, 1 = midscale |
| code_a | output | DATA_W | Converter register of channel A |
| code_b | output | DATA_W | Converter register of channel B |

## Verification
The assertions are written against the synchronised pin levels. They assume that every pin holds each level long enough for the two-stage synchroniser and the edge detector to see it. They also assume that the pins stay at idle levels while `rst` is high. The stimulus holds every pin value for five system cycles before it changes the next one, so no serial clock edge or select edge can be lost. Expected codes come from a small arithmetic model in the bench of the shift register and the two register stages. The model is advanced at each pin event.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int SDAC_NCH = 2;
  localparam int PIN_CS   = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_SDI  = 2;
  localparam int PIN_LOAD = 3;
  localparam int PIN_CLR  = 4;
  localparam int PIN_MID  = 5;
  localparam int PIN_W    = 6;
  localparam logic [PIN_W-1:0] PIN_IDLE = 6'b011001;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
  end
endmodule

// File: rtl/sdac_channel.sv
module sdac_channel #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_act,
  input  logic [DATA_W-1:0] clr_val,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              follow,
  output logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] dac_q
);
  logic [DATA_W-1:0] in_next;

  always_comb begin
    if (clr_act)    in_next = clr_val;
    else if (wr_en) in_next = wr_data;
    else            in_next = in_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      in_q <= in_next;
      if (clr_act)     dac_q <= clr_val;
      else if (follow) dac_q <= in_next;
    end
  end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              load_n,
  input  logic              clr_n,
  input  logic              mid_sel,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b
);
  localparam int WORD_W = DATA_W + SDAC_NCH;
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [PIN_W-1:0] pins_raw, pins_q;
  logic [1:0]       rise;
  logic             cs_q, sclk_q, sdi_q, load_n_q, clr_n_q, mid_q;
  logic             cs_rise, sclk_rise;
  logic [WORD_W-1:0] shreg;
  logic [DATA_W-1:0] clr_val;
  logic [DATA_W-1:0] in_arr  [SDAC_NCH];
  logic [DATA_W-1:0] dac_arr [SDAC_NCH];

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_CS]   = cs_n;
    pins_raw[PIN_SCLK] = sclk;
    pins_raw[PIN_SDI]  = sdi;
    pins_raw[PIN_LOAD] = load_n;
    pins_raw[PIN_CLR]  = clr_n;
    pins_raw[PIN_MID]  = mid_sel;
  end

  sdac_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_q)
  );

  assign cs_q     = pins_q[PIN_CS];
  assign sclk_q   = pins_q[PIN_SCLK];
  assign sdi_q    = pins_q[PIN_SDI];
  assign load_n_q = pins_q[PIN_LOAD];
  assign clr_n_q  = pins_q[PIN_CLR];
  assign mid_q    = pins_q[PIN_MID];

  sdac_edge #(.W(2), .RST_VAL(2'b01)) u_edge (
    .clk(clk), .rst(rst), .lvl({sclk_q, cs_q}), .rise(rise)
  );
  assign cs_rise   = rise[0];
  assign sclk_rise = rise[1];

  sdac_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(sclk_rise & ~cs_q), .bit_in(sdi_q), .word(shreg)
  );

  assign clr_val = mid_q ? MID_CODE : '0;

  for (genvar c = 0; c < SDAC_NCH; c++) begin : g_ch
    sdac_channel #(.DATA_W(DATA_W)) u_ch (
      .clk(clk),
      .rst(rst),
      .clr_act(~clr_n_q),
      .clr_val(clr_val),
      .wr_en(cs_rise & shreg[DATA_W + c]),
      .wr_data(shreg[DATA_W-1:0]),
      .follow(~load_n_q),
      .in_q(in_arr[c]),
      .dac_q(dac_arr[c])
    );
  end

  assign code_a = dac_arr[0];
  assign code_b = dac_arr[1];
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
  parameter int DATA_W = 16,
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_q,
  input logic              load_n_q,
  input logic              clr_n_q,
  input logic              mid_q,
  input logic [WORD_W-1:0] shreg,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [DATA_W-1:0] code_a,
  input logic [DATA_W-1:0] code_b
);
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (code_a == '0 && code_b == '0 && in_a == '0 && in_b == '0));

  a_r2_idle_no_shift: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> $stable(shreg));

  a_r5_follow_input: assert property (@(posedge clk) disable iff (rst)
    (!load_n_q && clr_n_q) |=> (code_a == in_a && code_b == in_b));

  a_r6_latched_hold: assert property (@(posedge clk) disable iff (rst)
    (load_n_q && clr_n_q) |=> ($stable(code_a) && $stable(code_b)));

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (!clr_n_q && !mid_q) |=> (code_a == '0 && code_b == '0 && in_a == '0 && in_b == '0));

  a_r8_clear_mid: assert property (@(posedge clk) disable iff (rst)
    (!clr_n_q && mid_q) |=> (code_a == MID_CODE && code_b == MID_CODE
                             && in_a == MID_CODE && in_b == MID_CODE));
endmodule

bind sdac_front sdac_front_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .cs_q(cs_q),
  .load_n_q(load_n_q),
  .clr_n_q(clr_n_q),
  .mid_q(mid_q),
  .shreg(shreg),
  .in_a(in_arr[0]),
  .in_b(in_arr[1]),
  .code_a(code_a),
  .code_b(code_b)
);

// File: tb/sdac_front_test.sv
module sdac_front_test;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic load_n = 1'b1, clr_n = 1'b1, mid_sel = 1'b0;
  logic [DW-1:0] code_a, code_b;

  logic [17:0]   m_sr = '0;
  logic [DW-1:0] m_ia = '0, m_ib = '0, m_da = '0, m_db = '0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdac_front #(.DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .load_n(load_n), .clr_n(clr_n), .mid_sel(mid_sel),
    .code_a(code_a), .code_b(code_b)
  );

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk(input string tag);
    checks++;
    if (code_a !== m_da || code_b !== m_db) begin
      fails++;
      $display("FAIL %s: actual a=%h b=%h expected a=%h b=%h",
               tag, code_a, code_b, m_da, m_db);
    end
  endtask

  task automatic upd_follow();
    if (clr_n && !load_n) begin
      m_da = m_ia;
      m_db = m_ib;
    end
  endtask

  task automatic send(input logic [17:0] w, input int n);
    cs_n = 1'b0; settle();
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i]; settle();
      sclk = 1'b1; settle();
      m_sr = {m_sr[16:0], w[i]};
      sclk = 1'b0; settle();
    end
    cs_n = 1'b1; settle();
    if (clr_n) begin
      if (m_sr[16]) m_ia = m_sr[15:0];
      if (m_sr[17]) m_ib = m_sr[15:0];
      upd_follow();
    end
  endtask

  task automatic set_load(input logic v);
    load_n = v; settle();
    upd_follow();
  endtask

  task automatic set_clr(input logic v, input logic mid);
    mid_sel = mid;
    clr_n = v; settle();
    if (!v) begin
      m_ia = mid ? 16'h8000 : 16'h0000;
      m_ib = m_ia; m_da = m_ia; m_db = m_ia;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    settle();
    chk("R1 reset state");

    // R3 / R4: address sweep with data patterns, load held high
    for (int a = 0; a < 4; a++) begin
      for (int j = 0; j < 6; j++) begin
        logic [DW-1:0] d;
        d = (j == 0) ? 16'h0000 : (j == 1) ? 16'hFFFF : DW'(j * 40503 + a * 977);
        send({2'(a), d}, 18);
        chk("R4 transfer leaves codes");
        set_load(1'b0);
        set_load(1'b1);
        chk("R3 address decode after load");
      end
    end

    // R5: transparent while load low
    set_load(1'b0);
    send({2'b01, 16'h3C5A}, 18); chk("R5 follow channel A");
    send({2'b10, 16'hA11E}, 18); chk("R5 follow channel B");
    send({2'b11, 16'h7E81}, 18); chk("R5 follow both");
    // R6: latched after load rises
    set_load(1'b1);
    send({2'b11, 16'h0F0F}, 18); chk("R6 hold after latch");
    send({2'b01, 16'hBEEF}, 18); chk("R6 hold second word");

    // R2: serial clocks with cs high do not shift
    set_load(1'b0);
    send({2'b01, 16'h1234}, 18); chk("R2 setup");
    sdi = 1'b1; settle();
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; settle();
      sclk = 1'b0; settle();
    end
    send(18'h0, 0); chk("R2 idle clocks ignored");

    // R10: short frames after a full frame
    for (int k = 0; k < 18; k++) begin
      send({2'b11, 16'hA5C3}, 18);
      send(18'(k * 18'h0B5D3 ^ 18'h2AAAA), k);
      chk("R10 short frame");
    end
    set_load(1'b1);

    // R7: clear to zero
    send({2'b11, 16'h4321}, 18);
    set_load(1'b0); set_load(1'b1);
    chk("R7 setup");
    set_clr(1'b0, 1'b0); chk("R7 clear zero");
    set_clr(1'b1, 1'b0);
    set_load(1'b0); chk("R7 input stage cleared");
    set_load(1'b1);

    // R8: clear to midscale
    send({2'b11, 16'h1357}, 18);
    set_load(1'b0); set_load(1'b1);
    chk("R8 setup");
    set_clr(1'b0, 1'b1); chk("R8 clear midscale");
    set_clr(1'b1, 1'b0);
    set_load(1'b0); chk("R8 input stage midscale");

    // R9: clear wins over transfer and transparent load
    set_clr(1'b0, 1'b0);
    send({2'b11, 16'hFFFF}, 18); chk("R9 transfer blocked");
    set_clr(1'b1, 1'b0);
    upd_follow(); chk("R9 input stage kept clear");
    set_load(1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule